// File: doc/BRIEF.md
# Coarse Timestamp Counter with Epoch and Sync Events

This block keeps the coarse time of a triggerless time-to-digital converter. A free-running counter advances on every clock cycle. Every hit strobe from up to four channels becomes an event word tagged with the counter value of the cycle in which the strobe was seen. The counter wraps at its full range. On each wrap the block puts an epoch word into the same output stream, carrying the number of wraps so far. The readout can then rebuild absolute time without any trigger.

An external sync line lets many chips share one time base. A rising edge on that line passes through a synchronizer and then forces the counter and the wrap count to zero. The block also emits a sync word carrying the counter value that was overwritten. Every event word is 24 bits wide and is held in a small FIFO. The FIFO is drained through a valid/ready handshake. When several events arise in one cycle, the FIFO accepts them all in a fixed order as long as there is room. Events that find no room are dropped, and a sticky flag records the loss.

Top module: `evt_timestamper`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `out_valid` and `ovf_flag` are 0. The counter reads zero in the first cycle after reset is released.
- R2: The counter advances by one on every clock edge unless a sync realignment happens. A high `hit_in[i]` in a cycle produces one word: bits [23:22] = 00, bits [21:20] = channel i, bits [19:0] = the counter value of that cycle, zero-extended.
- R3: When the counter steps from all ones to zero, an epoch word is emitted in the cycle in which the counter reads zero. Its fields are bits [23:22] = 01, bits [21:20] = 00, and bits [19:0] = the number of wraps since reset or the last sync.
- R4: A rising edge of `sync_in` that is first sampled at clock edge k makes the counter and the wrap count zero after edge k+2. The cycle before that edge emits a sync word: bits [23:22] = 10, bits [21:20] = 00, bits [19:0] = the counter value being replaced. When the realignment falls on the counter's last value, no wrap and no epoch word follow.
- R5: Holding `sync_in` high for many cycles causes exactly one realignment and one sync word.
- R6: Words that arise in the same cycle enter the stream in this order: epoch first, then hits in ascending channel number, then sync.
- R7: Hits on all channels in one cycle each produce their own word.
- R8: When the FIFO lacks room for all events of a cycle, the earliest events in the R6 order are kept and the rest are dropped. `ovf_flag` then rises and stays high until reset.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. A word is removed on a cycle with `out_valid` and `out_ready` both high.
- R10: Left running, the counter wraps every 2^CNT_W cycles, and each wrap produces exactly one epoch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External alignment line, asynchronous |
| hit_in | input | NCH | Per-channel hit strobes, one event per high cycle |
| out_data | output | 24 | Event word at the head of the FIFO |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Downstream accepts the head word |
| ovf_flag | output | 1 | Sticky flag, set when any event was dropped |

## Verification
The hardest case is a sync edge whose realignment lands exactly in the cycle after a wrap. In that cycle the epoch word, several hit words and the sync word are all written at once. A neighbouring case is a realignment on the counter's last value, which must suppress the wrap. The bench keeps its own model of the counter and of the synchronizer delay. It raises `sync_in` two cycles before the target counter value and drives hit strobes in the realignment cycle. Overflow is reached by holding `out_ready` low while all four channels fire for several cycles in a row.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int WORD_W = 24;
  localparam int PAY_W  = 20;
  localparam int CH_W   = 2;

  typedef enum logic [1:0] {
    EV_HIT   = 2'b00,
    EV_EPOCH = 2'b01,
    EV_SYNC  = 2'b10
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e          kind;
    logic [CH_W-1:0]   chan;
    logic [PAY_W-1:0]  payload;
  } ev_word_t;

  // assemble an event word from its fields
  function automatic logic [WORD_W-1:0] make_word(ev_kind_e k, logic [CH_W-1:0] c,
                                                  logic [PAY_W-1:0] p);
    ev_word_t w;
    w.kind    = k;
    w.chan    = c;
    w.payload = p;
    return w;
  endfunction

  // one wrap more in the epoch count
  function automatic logic [PAY_W-1:0] epoch_step(logic [PAY_W-1:0] e);
    return e + PAY_W'(1);
  endfunction

endpackage

// File: rtl/tsc_sync_edge.sv
module tsc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  // sh[0..STAGES-1] form the synchronizer chain, sh[STAGES] is the previous synced value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise_pulse = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/tsc_timebase.sv
module tsc_timebase #(
  parameter int CNT_W = 20,
  parameter int EP_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             realign,
  output logic [CNT_W-1:0] ts_now,
  output logic [EP_W-1:0]  epoch_num,
  output logic             epoch_due
);
  import tsc_pkg::*;

  localparam logic [CNT_W-1:0] TS_LAST = '1;

  logic at_last;
  assign at_last = (ts_now == TS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_now    <= '0;
      epoch_num <= '0;
      epoch_due <= 1'b0;
    end else if (realign) begin
      ts_now    <= '0;
      epoch_num <= '0;
      epoch_due <= 1'b0;
    end else if (at_last) begin
      ts_now    <= '0;
      epoch_num <= EP_W'(epoch_step(PAY_W'(epoch_num)));
      epoch_due <= 1'b1;
    end else begin
      ts_now    <= ts_now + CNT_W'(1);
      epoch_due <= 1'b0;
    end
  end

endmodule

// File: rtl/tsc_event_fifo.sv
module tsc_event_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 16,
  parameter int SLOTS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] push_vld,
  input  logic [W-1:0]     push_data [SLOTS],
  output logic [SLOTS-1:0] push_take,
  output logic             pop_vld,
  output logic [W-1:0]     pop_data,
  input  logic             pop_rdy
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill, free_n, taken;
  logic [AW-1:0] wr_idx [SLOTS];
  logic          pop_fire;

  assign free_n   = DEPTH_V - fill;
  assign pop_vld  = (fill != '0);
  assign pop_data = mem[rd_ptr];
  assign pop_fire = pop_vld & pop_rdy;

  // rank each request among the valid ones; keep those that still fit
  always_comb begin
    logic [AW:0] seen;
    seen  = '0;
    taken = '0;
    for (int i = 0; i < SLOTS; i++) begin
      wr_idx[i]    = wr_ptr + seen[AW-1:0];
      push_take[i] = push_vld[i] && (seen < free_n);
      taken        = taken + (AW+1)'(push_take[i]);
      seen         = seen + (AW+1)'(push_vld[i]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (push_take[i]) mem[wr_idx[i]] <= push_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr + taken[AW-1:0];
      rd_ptr <= rd_ptr + AW'(pop_fire);
      fill   <= fill + taken - (AW+1)'(pop_fire);
    end
  end

endmodule

// File: rtl/evt_timestamper.sv
module evt_timestamper
  import tsc_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CNT_W       = 20,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [NCH-1:0]    hit_in,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              ovf_flag
);
  localparam int SLOTS     = NCH + 2;
  localparam int EPOCH_SLOT = 0;
  localparam int SYNC_SLOT = NCH + 1;

  // named internal events, also observed by the checker
  logic              sync_pulse;
  logic              epoch_due;
  logic [CNT_W-1:0]  ts_now;
  logic [PAY_W-1:0]  epoch_num;
  logic [SLOTS-1:0]  slot_vld;
  logic [SLOTS-1:0]  slot_accept;
  logic [WORD_W-1:0] slot_word [SLOTS];
  logic              drop_now;

  tsc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (sync_in),
    .rise_pulse (sync_pulse)
  );

  tsc_timebase #(.CNT_W(CNT_W), .EP_W(PAY_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .realign   (sync_pulse),
    .ts_now    (ts_now),
    .epoch_num (epoch_num),
    .epoch_due (epoch_due)
  );

  // slot order fixes the stream order: epoch, hits by channel, sync
  assign slot_vld[EPOCH_SLOT]  = epoch_due;
  assign slot_word[EPOCH_SLOT] = make_word(EV_EPOCH, '0, epoch_num);

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign slot_vld[g+1]  = hit_in[g];
    assign slot_word[g+1] = make_word(EV_HIT, CH_W'(g), PAY_W'(ts_now));
  end

  assign slot_vld[SYNC_SLOT]  = sync_pulse;
  assign slot_word[SYNC_SLOT] = make_word(EV_SYNC, '0, PAY_W'(ts_now));

  tsc_event_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .SLOTS(SLOTS)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vld  (slot_vld),
    .push_data (slot_word),
    .push_take (slot_accept),
    .pop_vld   (out_valid),
    .pop_data  (out_data),
    .pop_rdy   (out_ready)
  );

  assign drop_now = |(slot_vld & ~slot_accept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (drop_now) ovf_flag <= 1'b1;
  end

endmodule

// File: rtl/evt_timestamper_chk.sv
module evt_timestamper_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_pulse,
  input logic             epoch_due,
  input logic             drop_now,
  input logic [CNT_W-1:0] ts_now,
  input logic             out_valid,
  input logic             out_ready,
  input logic [23:0]      out_data,
  input logic             ovf_flag
);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> ts_now == CNT_W'($past(ts_now) + 1'b1))
    else $error("counter did not advance by one");

  // R4
  sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> ts_now == '0)
    else $error("counter not zero after realignment");

  // R5
  sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse)
    else $error("realignment repeated on one edge");

  // R3
  epoch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_due |-> ts_now == '0)
    else $error("epoch word outside zero cycle");

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_now |=> ovf_flag)
    else $error("drop did not raise overflow flag");

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag)
    else $error("overflow flag cleared");

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("word changed while stalled");

endmodule

bind evt_timestamper evt_timestamper_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_pulse (sync_pulse),
  .epoch_due  (epoch_due),
  .drop_now   (drop_now),
  .ts_now     (ts_now),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .ovf_flag   (ovf_flag)
);

// File: tb/sim_evt_timestamper.sv
`timescale 1ns/1ps
module sim_evt_timestamper;
  localparam int NCH   = 4;
  localparam int CW    = 6;
  localparam int DEPTH = 8;
  localparam int MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic [NCH-1:0] hit_in = '0;
  logic out_ready = 1'b0;
  logic [23:0] out_data;
  logic out_valid, ovf_flag;

  always #4 clk = ~clk;

  evt_timestamper #(.NCH(NCH), .CNT_W(CW), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .hit_in(hit_in),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_fail = 0;
  int n_hit_seen = 0, n_epoch_seen = 0, n_sync_seen = 0;
  string cur_ph = "R2";

  function automatic void check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic string tag_of(logic [23:0] w);
    case (w[23:22])
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R2";
    endcase
  endfunction

  // ---------------- reference model: expected words queue ----------------
  logic [23:0] q[$];
  int  r_cnt = 0, r_ep = 0;
  bit  r_wrapq = 0, r_ovf = 0;
  bit  s1 = 0, s2 = 0, s3 = 0;
  bit  pop_pend = 0;

  task automatic push_exp(logic [23:0] w, int free_n, inout int seen);
    if (seen < free_n) q.push_back(w);
    else r_ovf = 1;           // R8: later events in order are dropped
    seen++;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      r_cnt = 0; r_ep = 0; r_wrapq = 0; r_ovf = 0;
      s1 = 0; s2 = 0; s3 = 0; pop_pend = 0;
    end else begin
      int free_n, seen;
      bit pulse;
      free_n = DEPTH - q.size();
      if (pop_pend && q.size() > 0) void'(q.pop_front());
      pop_pend = 0;
      pulse = s2 && !s3;
      seen = 0;
      // R6 order: epoch, hits by channel, sync
      if (r_wrapq) push_exp({2'b01, 2'b00, 20'(r_ep)}, free_n, seen);
      for (int c = 0; c < NCH; c++)
        if (hit_in[c]) push_exp({2'b00, 2'(c), 20'(r_cnt)}, free_n, seen);
      if (pulse) push_exp({2'b10, 2'b00, 20'(r_cnt)}, free_n, seen);
      if (pulse) begin
        r_cnt = 0; r_ep = 0; r_wrapq = 0;
      end else if (r_cnt == MAXC) begin
        r_cnt = 0; r_ep++; r_wrapq = 1;
      end else begin
        r_cnt++; r_wrapq = 0;
      end
      s3 = s2; s2 = s1; s1 = sync_in;
    end
  end

  // ---------------- monitor ----------------
  bit prev_stall = 0;
  logic [23:0] prev_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid != (q.size() > 0))
        check(0, cur_ph, "out_valid vs expected occupancy", int'(out_valid), int'(q.size() > 0));
      if (prev_stall)  // R9
        check(out_valid && out_data == prev_data, "R9", "stalled word changed",
              int'(out_data), int'(prev_data));
      if (out_valid && q.size() > 0 && out_ready) begin
        check(out_data == q[0], {tag_of(q[0]), "/", cur_ph}, "event word",
              int'(out_data), int'(q[0]));
        case (out_data[23:22])
          2'b01:   n_epoch_seen++;
          2'b10:   n_sync_seen++;
          default: n_hit_seen++;
        endcase
        pop_pend = 1;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end else begin
      prev_stall = 0;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_cnt(int v);
    do tick(); while (r_cnt != v);
  endtask

  task automatic pulse_hits(logic [NCH-1:0] m);
    hit_in = m; tick(); hit_in = '0;
  endtask

  task automatic run_all();
    int base;
    // R1 reset state
    repeat (3) tick();
    @(negedge clk);
    check(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    check(!ovf_flag, "R1", "ovf_flag in reset", int'(ovf_flag), 0);
    tick();
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !ovf_flag, "R1", "outputs after release", int'({out_valid, ovf_flag}), 0);
    out_ready = 1'b1;

    // R10: three natural wraps, one epoch each
    cur_ph = "R10";
    base = n_epoch_seen;
    repeat (200) tick();
    check(n_epoch_seen - base == 3, "R10", "epoch words over 200 cycles", n_epoch_seen - base, 3);

    // R2 single hits at various counter values
    cur_ph = "R2";
    wait_cnt(5);  pulse_hits(4'b0001);
    wait_cnt(17); pulse_hits(4'b0100);
    wait_cnt(40); pulse_hits(4'b1010);
    wait_cnt(MAXC); pulse_hits(4'b0010);

    // R7 all channels in one cycle
    cur_ph = "R7";
    repeat (4) tick();
    base = n_hit_seen;
    wait_cnt(22); pulse_hits(4'b1111);
    repeat (8) tick();
    check(n_hit_seen - base == 4, "R7", "hit words from one cycle", n_hit_seen - base, 4);

    // R6 epoch together with hits
    cur_ph = "R6";
    do tick(); while (!(r_cnt == 0 && r_wrapq));
    pulse_hits(4'b1011);
    repeat (6) tick();

    // R4/R6 realignment in the zero cycle after a wrap, with hits
    cur_ph = "R4";
    base = n_sync_seen;
    wait_cnt(MAXC - 1);
    sync_in = 1'b1;
    tick(); tick();
    hit_in = 4'b0110;
    tick();
    hit_in = '0; sync_in = 1'b0;
    repeat (10) tick();
    check(n_sync_seen - base == 1, "R4", "sync words after one edge", n_sync_seen - base, 1);

    // R4 realignment on the last counter value: no wrap follows
    wait_cnt(MAXC - 2);
    sync_in = 1'b1; tick(); sync_in = 1'b0;
    repeat (80) tick();

    // R5 long sync level
    cur_ph = "R5";
    base = n_sync_seen;
    sync_in = 1'b1;
    repeat (150) tick();
    sync_in = 1'b0;
    repeat (6) tick();
    check(n_sync_seen - base == 1, "R5", "sync words for long level", n_sync_seen - base, 1);

    // R8/R9 overflow under stall
    cur_ph = "R8";
    wait_cnt(10);
    out_ready = 1'b0;
    hit_in = 4'b1111;
    repeat (3) tick();
    hit_in = '0;
    repeat (6) tick();
    @(negedge clk);
    check(ovf_flag == 1'b1, "R8", "ovf_flag after 12 events into 8 entries", int'(ovf_flag), 1);
    check(out_valid == 1'b1, "R9", "valid held while stalled", int'(out_valid), 1);
    tick();
    out_ready = 1'b1;
    repeat (30) tick();
    @(negedge clk);
    check(ovf_flag == 1'b1, "R8", "ovf_flag sticky after drain", int'(ovf_flag), 1);

    // R9 mixed back-pressure with traffic
    cur_ph = "R9";
    for (int i = 0; i < 60; i++) begin
      out_ready = (i % 3) != 0;
      hit_in = 4'((i * 5) % 16) & {3'b000, (i % 4) == 0} * 4'hF;
      tick();
    end
    hit_in = '0;
    out_ready = 1'b1;
    repeat (40) tick();
    @(negedge clk);
    check(q.size() <= 1, "R9", "queue drained", q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule